// File: doc/BRIEF.md
# Interrupt Polarity and Latch Front End

This block sits between a set of peripheral interrupt wires and a parent interrupt controller that only accepts active-high level requests. Each input is brought into the clock domain, optionally inverted so that active-low levels and falling edges count as active, and then either passed on as a level or captured in a sticky latch, depending on how that line is configured at build time. A per-line mask gates the result, and the output to the parent is always a registered active-high level.

Software reaches the block through a small 16-bit register bus with byte addresses. Three banks hold the mask bits, the inversion bits and the acknowledge strobes. Each 16-bit word serves 16 lines, and consecutive words of a bank are four bytes apart. Software clears a captured edge by writing a one to that line's acknowledge bit. The mask and inversion words read back in full, so software can save the whole polarity setup and restore it later. A build option removes acknowledge support. In that build, edge-configured lines follow the corrected level.

Top module: `irq_level_front`

## Requirements
- R1: After a synchronous reset every output is 0, every mask bit reads 1 and every inversion bit reads 0.
- R2: A bus address hits only when bits [1:0] are 0 and every bit above bit 5 is 0. Bits [5:4] choose the bank (0 = mask, 1 = inversion, 2 = acknowledge) and bits [3:2] choose the group of 16 lines. A line's bit is its number mod 16. Any other address ignores writes and reads 0.
- R3: A mask bit of 1 holds that line's output at 0. A mask bit of 0 lets the corrected request through.
- R4: On a level line the output equals (input XOR inversion) AND NOT mask. It follows an input change on the third rising clock edge after the change.
- R5: An inversion bit of 1 makes a low input level count as active on a level line.
- R6: On an edge line, a 0-to-1 change of the corrected input sets a latch. The latch keeps the output high after the input returns to its idle level.
- R7: On an edge line with inversion 1, a falling input edge sets the latch and a rising input edge does not.
- R8: Writing 1 to a line's acknowledge bit clears its latch. Writing 0 there leaves the latch unchanged. The acknowledge bank always reads 0.
- R9: In the build without acknowledge support, acknowledge writes have no effect and edge-configured lines follow the corrected level.
- R10: Read data appears on the cycle after the address is presented. Mask and inversion words read back exactly the values last written for lines that exist.
- R11: The latch fills while the line is masked. Clearing the mask later makes the held request visible.
- R12: Lines numbered at or above the half-way point of the line count are edge lines by default, and lines below it are level lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Raw interrupt wires from peripherals, asynchronous |
| irq_out | output | NUM_LINES | Active-high level requests to the parent controller |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write enable for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the address of the previous cycle |

## Verification
The checks assume that a write is a single-cycle pulse of bus_we with a stable address and data. They also assume that reset is held for several cycles, with the raw inputs idle low, before any other traffic. The stimulus drives every bus signal and interrupt wire on the falling clock edge and holds each write for exactly one cycle. It leaves several cycles between an input change and the next check, so the synchronizer and the output register have settled. An inversion bit is changed only while its line is masked, and any latch that the change sets is acknowledged before the line is unmasked. This keeps spurious captures out of the checked outputs.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    BK_MASK = 2'd0,
    BK_POL  = 2'd1,
    BK_ACK  = 2'd2,
    BK_NONE = 2'd3
  } bank_e;

  // bits of a group word that map to existing lines
  function automatic logic [REG_W-1:0] live_bits(input int grp, input int lines);
    logic [REG_W-1:0] v;
    for (int b = 0; b < REG_W; b++) v[b] = ((grp * REG_W + b) < lines);
    return v;
  endfunction
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irqf_line.sv
module irqf_line #(
  parameter bit IS_EDGE = 1'b0,
  parameter bit HAS_ACK = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic invert,
  input  logic block,
  input  logic ack,
  output logic req,
  output logic pend
);
  logic corr;
  logic active;

  assign corr = sample ^ invert;

  if (IS_EDGE && HAS_ACK) begin : g_edge
    logic prev;
    logic held;
    always_ff @(posedge clk) begin
      if (rst) begin
        prev <= 1'b0;
        held <= 1'b0;
      end else begin
        prev <= corr;
        // a fresh edge wins over an acknowledge in the same cycle
        if (corr && !prev) held <= 1'b1;
        else if (ack)      held <= 1'b0;
      end
    end
    assign active = held;
    assign pend   = held;
  end else begin : g_level
    logic unused_ack;
    assign unused_ack = ack;
    assign active     = corr;
    assign pend       = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= active & ~block;
  end
endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
  import irqf_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 8,
  parameter bit HAS_ACK   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic [NUM_LINES-1:0] mask_bits,
  output logic [NUM_LINES-1:0] pol_bits,
  output logic [NUM_LINES-1:0] ack_stb
);
  localparam int GROUPS = (NUM_LINES + REG_W - 1) / REG_W;
  localparam int PADDED = GROUPS * REG_W;

  bank_e      bank;
  logic [1:0] grp;
  logic       hit;

  logic [REG_W-1:0]  mask_w [GROUPS];
  logic [REG_W-1:0]  pol_w  [GROUPS];
  logic [PADDED-1:0] mask_flat;
  logic [PADDED-1:0] pol_flat;
  logic [PADDED-1:0] ack_flat;

  always_comb begin
    bank = bank_e'(bus_addr[5:4]);
    grp  = bus_addr[3:2];
    hit  = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 6) == '0) &&
           (int'(grp) < GROUPS) && (bank != BK_NONE);
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [REG_W-1:0] LIVE = live_bits(g, NUM_LINES);
    logic sel;
    logic [REG_W-1:0] mask_g;
    logic [REG_W-1:0] pol_g;

    assign sel = bus_we && hit && (grp == 2'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_g <= LIVE;
        pol_g  <= '0;
      end else if (sel) begin
        if (bank == BK_MASK) mask_g <= bus_wdata & LIVE;
        if (bank == BK_POL)  pol_g  <= bus_wdata & LIVE;
      end
    end

    assign mask_w[g] = mask_g;
    assign pol_w[g]  = pol_g;
    assign mask_flat[g*REG_W +: REG_W] = mask_g;
    assign pol_flat[g*REG_W +: REG_W]  = pol_g;
    assign ack_flat[g*REG_W +: REG_W]  =
      (HAS_ACK && sel && bank == BK_ACK) ? (bus_wdata & LIVE) : '0;
  end

  assign mask_bits = mask_flat[NUM_LINES-1:0];
  assign pol_bits  = pol_flat[NUM_LINES-1:0];
  assign ack_stb   = ack_flat[NUM_LINES-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (hit) begin
        case (bank)
          BK_MASK: bus_rdata <= mask_w[grp];
          BK_POL:  bus_rdata <= pol_w[grp];
          default: bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_level_front.sv
module irq_level_front
  import irqf_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 8,
  parameter bit HAS_ACK   = 1'b1,
  parameter logic [NUM_LINES-1:0] EDGE_MASK = ~({NUM_LINES{1'b1}} >> (NUM_LINES / 2))
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata
);
  logic [NUM_LINES-1:0] synced;
  logic [NUM_LINES-1:0] mask_bits;
  logic [NUM_LINES-1:0] pol_bits;
  logic [NUM_LINES-1:0] ack_stb;
  logic [NUM_LINES-1:0] pend_bits;

  irqf_sync #(.W(NUM_LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_in),
    .q   (synced)
  );

  irqf_regs #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .HAS_ACK   (HAS_ACK)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask_bits (mask_bits),
    .pol_bits  (pol_bits),
    .ack_stb   (ack_stb)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irqf_line #(
      .IS_EDGE (EDGE_MASK[i]),
      .HAS_ACK (HAS_ACK)
    ) u_line (
      .clk    (clk),
      .rst    (rst),
      .sample (synced[i]),
      .invert (pol_bits[i]),
      .block  (mask_bits[i]),
      .ack    (ack_stb[i]),
      .req    (irq_out[i]),
      .pend   (pend_bits[i])
    );
  end
endmodule

// File: rtl/irqf_chk.sv
module irqf_chk #(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] irq_out,
  input logic [NUM_LINES-1:0] mask_bits,
  input logic [NUM_LINES-1:0] pend_bits,
  input logic [NUM_LINES-1:0] ack_stb,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [15:0]          bus_rdata
);
  logic rst_q;

  always_ff @(posedge clk) begin
    // R1
    if (rst_q) reset_quiet_chk: assert (irq_out == '0);
    rst_q <= rst;
  end

  // R8
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr[5:4]) == 2'b10) |-> (bus_rdata == 16'h0000));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_prop
    // R3
    mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
      irq_out[i] |-> !$past(mask_bits[i]));
    // R6
    latch_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_bits[i] && !ack_stb[i]) |=> pend_bits[i]);
  end
endmodule

bind irq_level_front irqf_chk #(
  .NUM_LINES (NUM_LINES),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_out   (irq_out),
  .mask_bits (mask_bits),
  .pend_bits (pend_bits),
  .ack_stb   (ack_stb),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/test_irq_level_front.sv
`timescale 1ns/1ps
module test_irq_level_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in  = '0;
  logic [15:0] irq2_in = '0;
  logic [63:0] irq_out;
  logic [15:0] irq2_out;
  logic [7:0]  bus_addr  = '0;
  logic        bus_we    = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] bus2_rdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_level_front i_irq_level_front (
    .clk (clk), .rst (rst), .irq_in (irq_in), .irq_out (irq_out),
    .bus_addr (bus_addr), .bus_we (bus_we), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  irq_level_front #(
    .NUM_LINES (16), .HAS_ACK (1'b0), .EDGE_MASK (16'hFFFF)
  ) i_irq_level_front_noack (
    .clk (clk), .rst (rst), .irq_in (irq2_in), .irq_out (irq2_out),
    .bus_addr (bus_addr), .bus_we (bus_we), .bus_wdata (bus_wdata),
    .bus_rdata (bus2_rdata)
  );

  // {input, mask, inversion} for lines 0..15 (level lines)
  localparam logic [47:0] VEC [6] = '{
    48'hFFFF_0000_0000,
    48'h00FF_0F0F_0000,
    48'h0000_0000_FFFF,
    48'hA5A5_0000_FF00,
    48'h1234_FFFF_0000,
    48'h8001_7FFE_0001
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [15:0] r;

  initial begin
    idle(5);
    @(negedge clk); rst = 1'b0;
    idle(2);
    // R1 reset state
    check("R1 outputs", irq_out, 64'h0);
    rd(8'h00, r); check("R1 mask g0", r, 16'hFFFF);
    rd(8'h0C, r); check("R1 mask g3", r, 16'hFFFF);
    rd(8'h10, r); check("R1 pol g0", r, 16'h0000);

    // R4 R5 R3: level lines under the vector table
    for (int k = 0; k < 6; k++) begin
      logic [15:0] vin, vm, vp;
      {vin, vm, vp} = VEC[k];
      wr(8'h00, vm);
      wr(8'h10, vp);
      @(negedge clk); irq_in[15:0] = vin;
      idle(6);
      check("R4 R5 R3 table", irq_out[15:0], (vin ^ vp) & ~vm);
    end

    // R2 address decoding
    wr(8'h01, 16'h0000);
    rd(8'h00, r); check("R2 misaligned write ignored", r, 16'h7FFE);
    wr(8'h40, 16'h0000);
    rd(8'h00, r); check("R2 high address ignored", r, 16'h7FFE);
    rd(8'h30, r); check("R2 unmapped bank reads zero", r, 16'h0000);

    // R10 readback of full words
    wr(8'h14, 16'hBEEF);
    rd(8'h14, r); check("R10 pol readback", r, 16'hBEEF);
    wr(8'h04, 16'h1234);
    rd(8'h04, r); check("R10 mask readback", r, 16'h1234);
    wr(8'h04, 16'hFFFF);
    wr(8'h14, 16'h0000);

    // R4 latency on line 0
    wr(8'h00, 16'h0000);
    wr(8'h10, 16'h0000);
    @(negedge clk); irq_in[15:0] = '0;
    idle(6);
    @(negedge clk); irq_in[0] = 1'b1;
    idle(2);
    check("R4 not yet after two edges", irq_out[0], 1'b0);
    idle(1);
    check("R4 visible on third edge", irq_out[0], 1'b1);

    // R6 R12 edge latch on line 32
    wr(8'h08, 16'hFFFE);
    @(negedge clk); irq_in[32] = 1'b1;
    idle(6);
    check("R6 edge captured", irq_out[32], 1'b1);
    @(negedge clk); irq_in[32] = 1'b0;
    idle(6);
    check("R6 R12 held after input idle", irq_out[32], 1'b1);
    rd(8'h28, r); check("R8 ack bank reads zero", r, 16'h0000);
    wr(8'h28, 16'h0000);
    idle(3);
    check("R8 zero ack keeps latch", irq_out[32], 1'b1);
    wr(8'h28, 16'h0001);
    idle(3);
    check("R8 ack clears", irq_out[32], 1'b0);

    // R7 falling edge with inversion on line 33
    @(negedge clk); irq_in[33] = 1'b1;
    idle(6);
    wr(8'h18, 16'h0002);
    idle(4);
    wr(8'h28, 16'h0002);
    wr(8'h08, 16'hFFFC);
    idle(4);
    check("R7 idle high input not active", irq_out[33], 1'b0);
    @(negedge clk); irq_in[33] = 1'b0;
    idle(6);
    check("R7 falling edge captured", irq_out[33], 1'b1);
    @(negedge clk); irq_in[33] = 1'b1;
    idle(6);
    check("R7 rising edge keeps latch", irq_out[33], 1'b1);
    wr(8'h28, 16'h0002);
    idle(3);
    check("R8 ack clears inverted line", irq_out[33], 1'b0);

    // R11 capture while masked on line 34
    @(negedge clk); irq_in[34] = 1'b1;
    idle(6);
    @(negedge clk); irq_in[34] = 1'b0;
    idle(6);
    check("R11 masked line silent", irq_out[34], 1'b0);
    wr(8'h08, 16'hFFF8);
    idle(3);
    check("R11 unmask reveals latch", irq_out[34], 1'b1);
    wr(8'h28, 16'h0004);
    idle(3);
    check("R11 R8 cleared after unmask", irq_out[34], 1'b0);

    // R9 build without acknowledge
    wr(8'h00, 16'h0000);
    @(negedge clk); irq2_in[0] = 1'b1;
    idle(6);
    check("R9 edge line follows level", irq2_out[0], 1'b1);
    wr(8'h20, 16'h0001);
    idle(3);
    check("R9 ack has no effect", irq2_out[0], 1'b1);
    @(negedge clk); bus_addr = 8'h00;
    @(negedge clk);
    check("R9 mask untouched", bus2_rdata, 16'h0000);
    @(negedge clk); irq2_in[0] = 1'b0;
    idle(6);
    check("R9 follows input low", irq2_out[0], 1'b0);

    // R1 reset in the middle of activity
    @(negedge clk); rst = 1'b1;
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(1);
    check("R1 outputs after second reset", irq_out, 64'h0);
    rd(8'h08, r); check("R1 mask reset again", r, 16'hFFFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule